// File: doc/BRIEF.md
# Video Stream Frame Capture

This block watches a raster pixel stream and turns it into frame-buffer writes. The stream carries two active-high sync levels, a pixel-valid strobe and three colour fields. The block keeps a column and a row position. Each pixel it accepts becomes one 32-bit word written at a linear address. A test environment uses it as the capture side of a display controller check: the stored image can be compared with the image that was meant to appear.

The position comes only from what is seen on the stream, never from timing parameters. A high-to-low change on the frame sync sends the row to zero and raises a one-cycle frame-done pulse. A high-to-low change on the line sync starts a new line, but only when at least one pixel has been taken on the current line. Both coordinates stop at the frame edge instead of wrapping. A position at the edge produces no write.

Writes and the frame pulse are registered. They appear one clock after the input cycle that caused them.

Top module: `pix_frame_grab`

## Requirements
- R1: While reset is asserted, `wrEn` and `frameDone` are 0. After reset the column, the row and both stored sync levels are 0, so the first valid pixel is written at address 0 and a sync that is low in the first cycle is not an edge.
- R2: A cycle where `vSyncIn` is 0 and was 1 in the previous cycle sets the row to 0. It also drives `frameDone` to 1 for exactly the next cycle.
- R3: A cycle where `hSyncIn` is 0 and was 1 in the previous cycle, while the column is non-zero, sets the column to 0 and adds one to the row.
- R4: A line-sync falling edge while the column is already 0 changes neither the column nor the row.
- R5: Each cycle with `pixValid` high produces, one clock later, `wrEn`=1 with `wrAddr` = column + row × FRAME_W. The column then increases by one. Cycles with `pixValid` low give `wrEn`=0.
- R6: The written word is red×2^19 + green×2^10 + blue×2^3, with the fields zero-extended to 32 bits.
- R7: The column saturates at FRAME_W. A valid pixel at column FRAME_W produces no write.
- R8: The row saturates at FRAME_H. A valid pixel at row FRAME_H produces no write.
- R9: Within one cycle the effects apply in this order: frame reset, then line advance, then the pixel write at the resulting position. A coincident frame edge, line edge and pixel (with a non-zero column) therefore writes at column 0 of row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hSyncIn | input | 1 | Line sync level |
| vSyncIn | input | 1 | Frame sync level |
| pixValid | input | 1 | Pixel present this cycle |
| redIn | input | RED_W | Red field |
| grnIn | input | GRN_W | Green field |
| bluIn | input | BLU_W | Blue field |
| wrEn | output | 1 | Frame-buffer write strobe |
| wrAddr | output | ADDR_W | Linear write address |
| wrData | output | 32 | Packed pixel word |
| frameDone | output | 1 | One-cycle pulse per frame-sync falling edge |

## Verification
The frame reset, the line advance and the pixel write can all fall in one input cycle. Their order decides where that pixel lands. The bench drives both syncs high for a cycle and then drops both together with a pixel present while the column is non-zero. It expects the pulse and a write at the start of row 1. Random traffic repeats such collisions, including ones at saturated positions. A behavioural model decides the expected position every cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic frameRst;
    logic lineAdv;
    logic pixWrite;
    logic pixStep;
  } pfgStrobes_t;

  // position flags from datapath to control
  typedef struct packed {
    logic hPrev;
    logic vPrev;
    logic xIsZero;
    logic xInside;
    logic yInside;
    logic yNextInside;
  } pfgStatus_t;

endpackage

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
#(
  parameter int FRAME_H = 480
) (
  input  logic        hSyncIn,
  input  logic        vSyncIn,
  input  logic        pixValid,
  input  pfgStatus_t  status,
  output pfgStrobes_t strobes
);

  localparam logic ROW1_INSIDE = (FRAME_H > 1);

  logic hFall;
  logic vFall;
  logic lineAdv;
  logic xOk;
  logic yOk;

  assign hFall   = status.hPrev & ~hSyncIn;
  assign vFall   = status.vPrev & ~vSyncIn;
  assign lineAdv = hFall & ~status.xIsZero;

  // bounds of the position after frame reset and line advance
  always_comb begin
    xOk = lineAdv | status.xInside;
    unique case ({vFall, lineAdv})
      2'b11:   yOk = ROW1_INSIDE;
      2'b10:   yOk = 1'b1;
      2'b01:   yOk = status.yNextInside;
      default: yOk = status.yInside;
    endcase
  end

  always_comb begin
    strobes.frameRst = vFall;
    strobes.lineAdv  = lineAdv;
    strobes.pixStep  = pixValid;
    strobes.pixWrite = pixValid & xOk & yOk;
  end

endmodule

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int RED_W   = 5,
  parameter int GRN_W   = 6,
  parameter int BLU_W   = 5,
  parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic [RED_W-1:0]  redIn,
  input  logic [GRN_W-1:0]  grnIn,
  input  logic [BLU_W-1:0]  bluIn,
  input  pfgStrobes_t       strobes,
  output pfgStatus_t        status,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              frameDone
);

  localparam int XW = $clog2(FRAME_W + 1);
  localparam int YW = $clog2(FRAME_H + 1);
  localparam int BW = $clog2(FRAME_W * FRAME_H + 1);
  localparam logic [XW-1:0] X_LIM  = XW'(FRAME_W);
  localparam logic [YW-1:0] Y_LIM  = YW'(FRAME_H);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_H - 1);
  localparam logic [BW-1:0] STRIDE = BW'(FRAME_W);

  logic [XW-1:0] xPos, xEff, xNext;
  logic [YW-1:0] yPos, yMid, yEff;
  logic [BW-1:0] lineBase, baseMid, baseEff;
  logic [BW-1:0] addrFull;
  logic          hPrev, vPrev;
  logic [31:0]   pixWord;

  assign status.hPrev       = hPrev;
  assign status.vPrev       = vPrev;
  assign status.xIsZero     = (xPos == '0);
  assign status.xInside     = (xPos < X_LIM);
  assign status.yInside     = (yPos < Y_LIM);
  assign status.yNextInside = (yPos < Y_LAST);

  // frame reset first, then line advance
  always_comb begin
    yMid    = strobes.frameRst ? '0 : yPos;
    baseMid = strobes.frameRst ? '0 : lineBase;
    xEff    = xPos;
    yEff    = yMid;
    baseEff = baseMid;
    if (strobes.lineAdv) begin
      xEff = '0;
      if (yMid < Y_LIM) begin
        yEff    = yMid + 1'b1;
        baseEff = baseMid + STRIDE;
      end
    end
  end

  always_comb begin
    xNext = xEff;
    if (strobes.pixStep && (xEff < X_LIM)) xNext = xEff + 1'b1;
  end

  assign addrFull = baseEff + BW'(xEff);
  assign pixWord  = (32'(redIn) << 19) + (32'(grnIn) << 10) + (32'(bluIn) << 3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos     <= '0;
      yPos     <= '0;
      lineBase <= '0;
      hPrev    <= 1'b0;
      vPrev    <= 1'b0;
    end else begin
      xPos     <= xNext;
      yPos     <= yEff;
      lineBase <= baseEff;
      hPrev    <= hSyncIn;
      vPrev    <= vSyncIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      frameDone <= 1'b0;
    end else begin
      wrEn      <= strobes.pixWrite;
      frameDone <= strobes.frameRst;
      if (strobes.pixWrite) begin
        wrAddr <= addrFull[ADDR_W-1:0];
        wrData <= pixWord;
      end
    end
  end

endmodule

// File: rtl/pix_frame_grab.sv
module pix_frame_grab
  import pfg_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int RED_W   = 5,
  parameter int GRN_W   = 6,
  parameter int BLU_W   = 5,
  parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              pixValid,
  input  logic [RED_W-1:0]  redIn,
  input  logic [GRN_W-1:0]  grnIn,
  input  logic [BLU_W-1:0]  bluIn,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              frameDone
);

  pfgStrobes_t strobes;
  pfgStatus_t  status;

  pfg_ctrl #(.FRAME_H(FRAME_H)) u_ctrl (
    .hSyncIn (hSyncIn),
    .vSyncIn (vSyncIn),
    .pixValid(pixValid),
    .status  (status),
    .strobes (strobes)
  );

  pfg_datapath #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
    .RED_W(RED_W), .GRN_W(GRN_W), .BLU_W(BLU_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hSyncIn  (hSyncIn),
    .vSyncIn  (vSyncIn),
    .redIn    (redIn),
    .grnIn    (grnIn),
    .bluIn    (bluIn),
    .strobes  (strobes),
    .status   (status),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .frameDone(frameDone)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int RED_W   = 5,
  parameter int GRN_W   = 6,
  parameter int BLU_W   = 5,
  parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input logic              clk,
  input logic              rstN,
  input logic              vSyncIn,
  input logic              pixValid,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              frameDone
);

  localparam logic [31:0] FIELD_MASK =
      ((32'(1) << RED_W) - 1) << 19 | ((32'(1) << GRN_W) - 1) << 10 | ((32'(1) << BLU_W) - 1) << 3;
  localparam int CELLS = FRAME_W * FRAME_H;

  logic vSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vSeen <= 1'b0;
    else       vSeen <= vSyncIn;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) reset_quiet_chk: assert (!wrEn && !frameDone);
  end

  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vSeen && !vSyncIn) |=> frameDone);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R5
  write_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrEn) |-> $past(pixValid));

  // R6
  word_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((wrData & ~FIELD_MASK) == 32'd0));

  // R8
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(wrAddr) < CELLS));

endmodule

bind pix_frame_grab pfg_checker #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
  .RED_W(RED_W), .GRN_W(GRN_W), .BLU_W(BLU_W), .ADDR_W(ADDR_W)
) u_pfg_checker (
  .clk(clk), .rstN(rstN), .vSyncIn(vSyncIn), .pixValid(pixValid),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .frameDone(frameDone)
);

// File: tb/test_pix_frame_grab.sv
`timescale 1ns/1ps
module test_pix_frame_grab;

  localparam int W  = 20;
  localparam int H  = 6;
  localparam int AW = $clog2(W * H);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hIn = 1'b0, vIn = 1'b0, en = 1'b0;
  logic [4:0] rIn = '0;
  logic [5:0] gIn = '0;
  logic [4:0] bIn = '0;
  logic wrEn, frameDone;
  logic [AW-1:0] wrAddr;
  logic [31:0] wrData;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pix_frame_grab #(.FRAME_W(W), .FRAME_H(H)) i_pix_frame_grab (
    .clk(clk), .rstN(rstN), .hSyncIn(hIn), .vSyncIn(vIn), .pixValid(en),
    .redIn(rIn), .grnIn(gIn), .bluIn(bIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .frameDone(frameDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int mx = 0, my = 0;
  bit mh = 0, mv = 0, armed = 0;
  bit eWr = 0, eFd = 0;
  int eAddr = 0;
  logic [31:0] eData = '0;
  string eTag = "R5";

  always @(posedge clk) begin
    if (!rstN) begin
      mx = 0; my = 0; mh = 0; mv = 0; eWr = 0; eFd = 0; armed = 0;
    end else begin
      bit vf, hf;
      vf = mv && !vIn;
      hf = mh && !hIn;
      eTag = "R5";
      if (vf) my = 0;
      if (hf && mx != 0) begin
        my = (my + 1 >= H) ? H : my + 1;
        mx = 0;
        eTag = vf ? "R9" : "R3";
      end else if (hf) eTag = "R4";
      eFd = vf;
      eWr = 0;
      if (en) begin
        if (mx < W && my < H) begin
          eWr = 1;
          eAddr = mx + my * W;
          eData = 32'(rIn) * 32'd524288 + 32'(gIn) * 32'd1024 + 32'(bIn) * 32'd8;
        end else eTag = (mx >= W) ? "R7" : "R8";
        mx = (mx + 1 >= W) ? W : mx + 1;
      end
      mh = hIn; mv = vIn;
      armed = 1;
    end
  end

  always @(negedge clk) begin
    if (armed && rstN) begin
      chk("R2 frameDone", 32'(frameDone), 32'(eFd));
      chk({eTag, " wrEn"}, 32'(wrEn), 32'(eWr));
      if (eWr) begin
        chk({eTag, " wrAddr"}, 32'(wrAddr), 32'(eAddr));
        chk("R6 wrData", wrData, eData);
      end
    end
  end

  task automatic drive(input bit h, input bit v, input bit e, input int seed);
    hIn = h; vIn = v; en = e;
    rIn = 5'(seed * 7 + 3); gIn = 6'(seed * 13 + 1); bIn = 5'(seed * 5 + 2);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    hIn = 1; vIn = 1; en = 1;
    repeat (3) @(negedge clk);
    chk("R1 wrEn in reset", 32'(wrEn), 32'd0);
    chk("R1 frameDone in reset", 32'(frameDone), 32'd0);
    hIn = 0; vIn = 0; en = 0;
    @(negedge clk);
    rstN = 1;
    // R1: syncs low in first cycle, stored history 0 -> no edge; pixel at 0
    drive(0, 0, 1, 1);
    drive(0, 0, 1, 2);
    // R2 frame edge
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 3);
    drive(0, 0, 1, 4);
    drive(0, 0, 1, 5);
    // R3 line edge with x nonzero
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 6);
    // R4 line edge at x == 0
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 7);
    // R7 column saturation
    for (int i = 0; i < W + 5; i++) drive(0, 0, 1, i);
    // R8 row saturation
    for (int l = 0; l < H + 3; l++) begin
      drive(1, 0, 1, l);
      drive(0, 0, 1, l + 1);
      drive(0, 0, 1, l + 2);
    end
    // R9 coincident frame edge, line edge and pixel
    drive(0, 0, 1, 9);
    drive(1, 1, 1, 10);
    drive(0, 0, 1, 11);
    drive(0, 0, 1, 12);
    // R1 reset mid-stream
    rstN = 0;
    drive(1, 1, 1, 13);
    hIn = 0; vIn = 0;
    @(negedge clk);
    rstN = 1;
    drive(0, 0, 1, 14);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      bit h, v, e;
      h = ($urandom % 6 == 0) ? ~hIn : hIn;
      v = ($urandom % 60 == 0) ? ~vIn : vIn;
      e = ($urandom % 4 != 0);
      drive(h, v, e, int'($urandom % 64));
    end
    drive(0, 0, 0, 0);
    finish_run();
  end

endmodule